// File: doc/BRIEF.md
# Protected Address Range Register Pair

This block stores one memory-protection window as two page-granular registers: a low bound and a high bound. Software reaches both through a small register port. Every access on that port carries a supervisor bit and a secure bit. A write changes a register only when the access holds enough privilege. How much privilege is enough depends on a non-secure flag, which comes from a neighbouring permission register. A rejected write leaves the window alone and raises a one-cycle violation pulse.

Only the page-number field is stored. On read-back, the bits below the page are filled with zeros in the low bound and with ones in the high bound, so the window includes the last byte of its final page. The page size is a per-instance parameter. The same block therefore serves both fine-grained (1 KB) and coarse (64 KB) protection units. A combinational comparator tests a checked address against the composed bounds and drives a hit flag.

Top module: `prot_range_pair`

## Requirements
- R1: A write with `wr_en`=1, `priv_sup`=1 and either `ns_flag`=1 or `priv_sec`=1 loads `wdata[31:OFS]` into the register chosen by `sel_end` (0 = low bound, 1 = high bound) at that clock edge. OFS is log2 of `PAGE_BYTES`.
- R2: A write with `priv_sup`=0 changes neither register.
- R3: When `ns_flag`=0, a supervisor write with `priv_sec`=0 changes neither register.
- R4: A read of the low bound returns 0 in bits OFS-1..0, whatever was written there.
- R5: A read of the high bound returns all ones in bits OFS-1..0, whatever was written there.
- R6: `PAGE_BYTES` sets the stored field width. With 65536, bits 15..0 are sub-page bits, and with the default of 1024, bits 9..0 are.
- R7: Reads need no privilege. `rdata` takes the composed value of the selected register on the clock edge where `rd_en`=1, and holds while `rd_en`=0.
- R8: After a synchronous reset the low bound reads 0 and the high bound reads 0xFFFFFFFF. `rdata` and `wr_viol` are 0.
- R9: `hit` is 1 exactly when `chk_addr` is at or above the composed low bound and at or below the composed high bound (unsigned, combinational).
- R10: A rejected write raises `wr_viol` on the following cycle. The pulse lasts one cycle unless the next write is also rejected. An accepted write, or no write, gives `wr_viol`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| sel_end | input | 1 | Register select: 0 low bound, 1 high bound |
| wdata | input | ADDR_W | Write data |
| priv_sup | input | 1 | Access is supervisor |
| priv_sec | input | 1 | Access is secure |
| ns_flag | input | 1 | Non-secure flag from the permission register |
| chk_addr | input | ADDR_W | Address tested against the window |
| rdata | output | ADDR_W | Registered read data |
| wr_viol | output | 1 | One-cycle pulse for a rejected write |
| hit | output | 1 | Checked address lies inside the window |

## Verification
The sub-page fill and the privilege decision are the two places where a wrong internal state would hide. A corrupted stored field shows up on `hit` in the same cycle that the bench sets a boundary address. It also shows up on `rdata` one clock after a read of that register. A wrong privilege decision shows up as a missing or extra `wr_viol` one cycle after the write. A later read-back of the changed bound confirms it. Two instances with different page sizes are driven with identical traffic, so a fill-width error shows as the two instances disagreeing.

// File: rtl/prot_range_pkg.sv
package prot_range_pkg;

  typedef enum logic {
    REG_LO = 1'b0,
    REG_HI = 1'b1
  } range_reg_e;

  typedef struct packed {
    logic sup;
    logic sec;
  } access_attr_t;

  function automatic logic write_allowed(access_attr_t a, logic ns);
    return a.sup && (ns || a.sec);
  endfunction

endpackage

// File: rtl/prot_range_gate.sv
module prot_range_gate
  import prot_range_pkg::*;
(
  input  logic wr_en,
  input  logic sel_end,
  input  logic priv_sup,
  input  logic priv_sec,
  input  logic ns_flag,
  output logic ld_lo,
  output logic ld_hi,
  output logic reject
);

  access_attr_t attr;
  logic         ok;

  always_comb begin
    attr.sup = priv_sup;
    attr.sec = priv_sec;
    ok       = write_allowed(attr, ns_flag);
    ld_lo    = wr_en && ok && (range_reg_e'(sel_end) == REG_LO);
    ld_hi    = wr_en && ok && (range_reg_e'(sel_end) == REG_HI);
    reject   = wr_en && !ok;
  end

endmodule

// File: rtl/prot_range_field.sv
module prot_range_field #(
  parameter int  ADDR_W = 32,
  parameter int  OFS_W  = 10,
  parameter bit  FILL   = 1'b0,
  localparam int FLD_W  = ADDR_W - OFS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [FLD_W-1:0]  din,
  output logic [ADDR_W-1:0] full
);

  logic [FLD_W-1:0] fld_q;

  always_ff @(posedge clk) begin
    if (rst)       fld_q <= {FLD_W{FILL}};
    else if (load) fld_q <= din;
  end

  assign full = {fld_q, {OFS_W{FILL}}};

endmodule

// File: rtl/prot_range_read.sv
module prot_range_read #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              sel_end,
  input  logic              reject,
  input  logic [ADDR_W-1:0] lo_full,
  input  logic [ADDR_W-1:0] hi_full,
  output logic [ADDR_W-1:0] rdata,
  output logic              wr_viol
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata   <= '0;
      wr_viol <= 1'b0;
    end else begin
      wr_viol <= reject;
      if (rd_en) rdata <= sel_end ? hi_full : lo_full;
    end
  end

endmodule

// File: rtl/prot_range_hit.sv
module prot_range_hit #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] chk_addr,
  input  logic [ADDR_W-1:0] lo_full,
  input  logic [ADDR_W-1:0] hi_full,
  output logic              hit
);

  logic above_lo;
  logic below_hi;

  always_comb begin
    above_lo = (chk_addr >= lo_full);
    below_hi = (chk_addr <= hi_full);
    hit      = above_lo && below_hi;
  end

endmodule

// File: rtl/prot_range_pair.sv
module prot_range_pair #(
  parameter int  ADDR_W     = 32,
  parameter int  PAGE_BYTES = 1024,
  localparam int OFS_W      = $clog2(PAGE_BYTES),
  localparam int FLD_W      = ADDR_W - OFS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              sel_end,
  input  logic [ADDR_W-1:0] wdata,
  input  logic              priv_sup,
  input  logic              priv_sec,
  input  logic              ns_flag,
  input  logic [ADDR_W-1:0] chk_addr,
  output logic [ADDR_W-1:0] rdata,
  output logic              wr_viol,
  output logic              hit
);

  logic              ld_lo, ld_hi, reject;
  logic [ADDR_W-1:0] lo_full, hi_full;
  logic [1:0]        ld_vec;
  logic [ADDR_W-1:0] full_vec [2];

  prot_range_gate gate_i (
    .wr_en   (wr_en),
    .sel_end (sel_end),
    .priv_sup(priv_sup),
    .priv_sec(priv_sec),
    .ns_flag (ns_flag),
    .ld_lo   (ld_lo),
    .ld_hi   (ld_hi),
    .reject  (reject)
  );

  assign ld_vec = {ld_hi, ld_lo};

  for (genvar g = 0; g < 2; g++) begin : g_bound
    prot_range_field #(
      .ADDR_W(ADDR_W),
      .OFS_W (OFS_W),
      .FILL  (g == 1)
    ) field_i (
      .clk (clk),
      .rst (rst),
      .load(ld_vec[g]),
      .din (wdata[ADDR_W-1:OFS_W]),
      .full(full_vec[g])
    );
  end

  assign lo_full = full_vec[0];
  assign hi_full = full_vec[1];

  prot_range_read #(.ADDR_W(ADDR_W)) read_i (
    .clk    (clk),
    .rst    (rst),
    .rd_en  (rd_en),
    .sel_end(sel_end),
    .reject (reject),
    .lo_full(lo_full),
    .hi_full(hi_full),
    .rdata  (rdata),
    .wr_viol(wr_viol)
  );

  prot_range_hit #(.ADDR_W(ADDR_W)) hit_i (
    .chk_addr(chk_addr),
    .lo_full (lo_full),
    .hi_full (hi_full),
    .hit     (hit)
  );

endmodule

// File: rtl/prot_range_chk.sv
module prot_range_chk #(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic              sel_end,
  input logic [ADDR_W-1:0] wdata,
  input logic              priv_sup,
  input logic              priv_sec,
  input logic              ns_flag,
  input logic [ADDR_W-1:0] chk_addr,
  input logic [ADDR_W-1:0] rdata,
  input logic              wr_viol,
  input logic              hit,
  input logic [ADDR_W-1:0] lo_full,
  input logic [ADDR_W-1:0] hi_full
);

  logic good_wr, bad_wr;
  assign good_wr = wr_en && priv_sup && (ns_flag || priv_sec);
  assign bad_wr  = wr_en && !(priv_sup && (ns_flag || priv_sec));

  assert_load_lo_R1: assert property (@(posedge clk) disable iff (rst)
    (good_wr && !sel_end) |=> lo_full[ADDR_W-1:OFS_W] == $past(wdata[ADDR_W-1:OFS_W]));

  assert_load_hi_R1: assert property (@(posedge clk) disable iff (rst)
    (good_wr && sel_end) |=> hi_full[ADDR_W-1:OFS_W] == $past(wdata[ADDR_W-1:OFS_W]));

  assert_nonsup_ignored_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !priv_sup) |=> ($stable(lo_full) && $stable(hi_full)));

  assert_secure_needed_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !ns_flag && !priv_sec) |=> ($stable(lo_full) && $stable(hi_full)));

  assert_lo_fill_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !sel_end) |=> rdata[OFS_W-1:0] == '0);

  assert_hi_fill_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_en && sel_end) |=> rdata[OFS_W-1:0] == '1);

  assert_rdata_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));

  assert_reset_state_R8: assert property (@(posedge clk)
    $fell(rst) |-> (lo_full == '0 && hi_full == '1 && !wr_viol));

  assert_hit_window_R9: assert property (@(posedge clk) disable iff (rst)
    hit == ((chk_addr >= lo_full) && (chk_addr <= hi_full)));

  assert_viol_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    bad_wr |=> wr_viol);

  assert_viol_cause_R10: assert property (@(posedge clk) disable iff (rst)
    !bad_wr |=> !wr_viol);

endmodule

bind prot_range_pair prot_range_chk #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) chk_i (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .rd_en   (rd_en),
  .sel_end (sel_end),
  .wdata   (wdata),
  .priv_sup(priv_sup),
  .priv_sec(priv_sec),
  .ns_flag (ns_flag),
  .chk_addr(chk_addr),
  .rdata   (rdata),
  .wr_viol (wr_viol),
  .hit     (hit),
  .lo_full (lo_full),
  .hi_full (hi_full)
);

// File: tb/prot_range_pair_tb_top.sv
module prot_range_pair_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0, sel_end = 1'b0;
  logic [31:0] wdata = '0, chk_addr = '0;
  logic        priv_sup = 1'b0, priv_sec = 1'b0, ns_flag = 1'b0;
  logic [31:0] rdata_a, rdata_b;
  logic        viol_a, viol_b, hit_a, hit_b;

  int n_cmp = 0, n_bad = 0;
  logic [31:0] lo_a = 32'h0, hi_a = 32'hFFFF_FFFF;
  logic [31:0] lo_b = 32'h0, hi_b = 32'hFFFF_FFFF;

  always #10 clk = ~clk;

  prot_range_pair #(.ADDR_W(32), .PAGE_BYTES(1024)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .sel_end(sel_end),
    .wdata(wdata), .priv_sup(priv_sup), .priv_sec(priv_sec), .ns_flag(ns_flag),
    .chk_addr(chk_addr), .rdata(rdata_a), .wr_viol(viol_a), .hit(hit_a));

  prot_range_pair #(.ADDR_W(32), .PAGE_BYTES(65536)) dut64_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .sel_end(sel_end),
    .wdata(wdata), .priv_sup(priv_sup), .priv_sec(priv_sec), .ns_flag(ns_flag),
    .chk_addr(chk_addr), .rdata(rdata_b), .wr_viol(viol_b), .hit(hit_b));

  function automatic logic [31:0] compose(logic [31:0] d, int ofs, logic hi);
    logic [31:0] m = (32'h1 << ofs) - 32'h1;
    return hi ? (d | m) : (d & ~m);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(logic sel, logic [31:0] d, logic sup, logic sec, logic ns);
    logic ok = sup && (ns || sec);
    string req = ok ? "R1" : (!sup ? "R2" : "R3");
    @(negedge clk);
    wr_en = 1'b1; sel_end = sel; wdata = d;
    priv_sup = sup; priv_sec = sec; ns_flag = ns;
    @(negedge clk);
    wr_en = 1'b0;
    if (ok) begin
      if (sel) begin hi_a = compose(d, 10, 1'b1); hi_b = compose(d, 16, 1'b1); end
      else     begin lo_a = compose(d, 10, 1'b0); lo_b = compose(d, 16, 1'b0); end
    end
    check({req, " R10 viol 1K"}, {31'b0, viol_a}, {31'b0, !ok});
    check({req, " R10 viol 64K"}, {31'b0, viol_b}, {31'b0, !ok});
  endtask

  task automatic do_read(logic sel);
    @(negedge clk);
    rd_en = 1'b1; sel_end = sel;
    priv_sup = 1'b0; priv_sec = 1'b0;
    @(negedge clk);
    rd_en = 1'b0;
    check(sel ? "R5 R7 hi read 1K" : "R4 R7 lo read 1K", rdata_a, sel ? hi_a : lo_a);
    check(sel ? "R5 R6 hi read 64K" : "R4 R6 lo read 64K", rdata_b, sel ? hi_b : lo_b);
  endtask

  task automatic do_hit(logic [31:0] a);
    logic ea, eb;
    chk_addr = a;
    #1;
    ea = (a >= lo_a) && (a <= hi_a);
    eb = (a >= lo_b) && (a <= hi_b);
    check("R9 hit 1K", {31'b0, hit_a}, {31'b0, ea});
    check("R9 R6 hit 64K", {31'b0, hit_b}, {31'b0, eb});
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : stim
    logic [31:0] seed;
    logic [31:0] held;
    seed = $urandom(32'd1357);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R8 rdata after reset", rdata_a, 32'h0);
    check("R8 viol after reset", {31'b0, viol_a}, 32'h0);
    do_read(1'b0);
    do_read(1'b1);
    do_hit(32'h0);
    do_hit(32'hFFFF_FFFF);

    do_write(1'b0, 32'h1234_5678, 1'b1, 1'b1, 1'b0);
    do_read(1'b0);
    do_write(1'b1, 32'h1234_5ABC, 1'b1, 1'b0, 1'b1);
    do_read(1'b1);
    held = rdata_a;
    @(negedge clk);
    check("R7 rdata holds", rdata_a, held);
    do_hit(32'h1234_53FF);
    do_hit(32'h1234_5400);
    do_hit(32'h1234_5BFF);
    do_hit(32'h1234_5C00);
    do_hit(32'h1234_FFFF);
    do_hit(32'h1235_0000);

    do_write(1'b0, 32'hAAAA_AAAA, 1'b0, 1'b1, 1'b1);
    do_read(1'b0);
    do_write(1'b1, 32'h0000_0000, 1'b1, 1'b0, 1'b0);
    do_read(1'b1);
    do_write(1'b0, 32'h5555_5555, 1'b1, 1'b0, 1'b0);
    do_write(1'b0, 32'h6666_6666, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    check("R10 pulse ends", {31'b0, viol_a}, 32'h0);
    do_read(1'b0);

    for (int i = 0; i < 400; i++) begin
      logic [2:0] op = 3'($urandom_range(0, 5));
      if (op < 3'd2)
        do_write(1'($urandom), $urandom, 1'($urandom), 1'($urandom), 1'($urandom));
      else if (op < 3'd4)
        do_read(1'($urandom));
      else if (op == 3'd4)
        do_hit($urandom);
      else
        do_hit((($urandom & 1) != 0 ? lo_a : hi_a) + 32'($signed($urandom_range(0, 2)) - 1));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule